// File: doc/BRIEF.md
# Presettable Cascadable Up/Down Counter

This block is a small synchronous binary counter with a preset path. Every state change happens on the rising edge of one shared clock. A clear input and a load input are both sampled on that edge, and both are active low. Two count enables must both be high before the counter advances. A direction input chooses whether each step adds one or subtracts one. A preset takes its value from a parallel data bus.

The block drives a terminal-count output for cascading. This output is high when the count sits at the end of its range for the current direction and the chaining enable is high. It does not depend on the local enable. To build a wider counter, the terminal-count output of one stage feeds the chaining enable of the next stage. The local enable of every stage is driven from a common source.

Top module: `updn_counter`

## Requirements
- R1: When `clrN` is 0 at a rising clock edge, `count` becomes 0 after that edge, whatever the values of load, enables, direction and data.
- R2: When `clrN` is 1 and `loadN` is 0 at an edge, `count` takes the value of `dataIn` (bit 0 is the least significant bit).
- R3: When `clrN` and `loadN` are both 1 and either `enLocal` or `enChain` is 0, `count` keeps its value across the edge.
- R4: When `clrN`, `loadN`, `enLocal` and `enChain` are all 1 and `countUp` is 1, `count` increases by one. All ones wraps to 0.
- R5: Under the same conditions with `countUp` 0, `count` decreases by one. Zero wraps to all ones.
- R6: `carryOut` is 1 exactly when `enChain` is 1 and the count is at its limit: all ones when `countUp` is 1, or zero when `countUp` is 0.
- R7: `carryOut` follows `count`, `countUp` and `enChain` combinationally within the same cycle, and it does not depend on `enLocal`.
- R8: A load takes effect even when both enables are 0. The direction applied is the value of `countUp` at the edge.
- R9: When two stages are chained, with the lower stage's `carryOut` driving the upper stage's `enChain`, the pair counts up and down as one 2*WIDTH-bit value, wrapping at both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge active |
| clrN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous parallel load, active low |
| enLocal | input | 1 | Count enable that does not gate the terminal-count output |
| enChain | input | 1 | Count enable that also gates the terminal-count output |
| countUp | input | 1 | Direction: 1 counts up, 0 counts down |
| dataIn | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| carryOut | output | 1 | Terminal count for the chaining enable of the next stage |

## Verification
The bench presets every value and then applies all four enable combinations in both directions. This exposes a design that advances on a single enable, or that gates the terminal count with the wrong enable, or with none at all. Clear is asserted together with an active load to confirm the priority order, and loads are issued with both enables low. Two chained stages are run across their full 8-bit range upward and then downward. A wrong wrap, or a terminal count at the wrong end of the range, would show up as a misstep in the upper nibble at the 15/0 boundaries.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

  // Per-edge action requested by the control module; at most one of
  // clear, load and step is set in any cycle.
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
    logic up;
  } ctrlStrobe_t;

endpackage

// File: rtl/updn_ctr_control.sv
module updn_ctr_control
  import updn_ctr_pkg::*;
(
  input  logic        clrN,
  input  logic        loadN,
  input  logic        enLocal,
  input  logic        enChain,
  input  logic        countUp,
  input  logic        atLimit,
  output ctrlStrobe_t strobe,
  output logic        carryOut
);

  // Fixed priority: clear, then load, then count, otherwise hold.
  always_comb begin
    strobe.clear = ~clrN;
    strobe.load  = clrN & ~loadN;
    strobe.step  = clrN & loadN & enLocal & enChain;
    strobe.up    = countUp;
  end

  // Terminal count gated only by the chaining enable.
  assign carryOut = atLimit & enChain;

  // R1 R2: the priority decode never requests two actions together.
  always_comb begin
    if (clrN !== 1'bx && loadN !== 1'bx)
      a_r1_single_action: assert ($onehot0({strobe.clear, strobe.load, strobe.step}));
  end

endmodule

// File: rtl/updn_ctr_datapath.sv
module updn_ctr_datapath
  import updn_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             atLimit
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;

  always_comb begin
    if (strobe.clear)      countNext = ZERO;
    else if (strobe.load)  countNext = dataIn;
    else if (strobe.step)  countNext = strobe.up ? countQ + ONE : countQ - ONE;
    else                   countNext = countQ;
  end

  always_ff @(posedge clk) begin
    countQ <= countNext;
  end

  // Limit of the range in the selected direction.
  assign atLimit = strobe.up ? (&countQ) : ~(|countQ);
  assign count   = countQ;

endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic             enLocal,
  input  logic             enChain,
  input  logic             countUp,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  ctrlStrobe_t strobe;
  logic        atLimit;

  updn_ctr_control u_control (
    .clrN     (clrN),
    .loadN    (loadN),
    .enLocal  (enLocal),
    .enChain  (enChain),
    .countUp  (countUp),
    .atLimit  (atLimit),
    .strobe   (strobe),
    .carryOut (carryOut)
  );

  updn_ctr_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk     (clk),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .count   (count),
    .atLimit (atLimit)
  );

  // Checks are held off until the count has been given a defined value.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clrN || !loadN) armed <= 1'b1;
  end

  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!armed)
    !clrN |=> count == '0);

  a_r2_load_data: assert property (@(posedge clk) disable iff (!armed)
    (clrN && !loadN) |=> count == $past(dataIn));

  a_r3_hold: assert property (@(posedge clk) disable iff (!armed)
    (clrN && loadN && !(enLocal && enChain)) |=> $stable(count));

  a_r4_up_wrap: assert property (@(posedge clk) disable iff (!armed)
    (clrN && loadN && enLocal && enChain && countUp && count == ALL_ONES) |=> count == '0);

  a_r5_down_wrap: assert property (@(posedge clk) disable iff (!armed)
    (clrN && loadN && enLocal && enChain && !countUp && count == '0) |=> count == ALL_ONES);

  a_r6_carry_gated: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> enChain);

endmodule

// File: tb/sim_updn_counter.sv
`timescale 1ns/1ps
module sim_updn_counter;

  logic       clk = 1'b0;
  logic       clrN, loadN, enLocal, enChain, countUp;
  logic [3:0] dLo, dHi;
  logic [3:0] qLo, qHi;
  logic       carryLo, carryHi;
  int         nChecks = 0;
  int         nFails  = 0;
  bit         finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  updn_counter #(.WIDTH(4)) u0 (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enLocal(enLocal), .enChain(enChain),
    .countUp(countUp), .dataIn(dLo), .count(qLo), .carryOut(carryLo));

  updn_counter #(.WIDTH(4)) u1 (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enLocal(enLocal), .enChain(carryLo),
    .countUp(countUp), .dataIn(dHi), .count(qHi), .carryOut(carryHi));

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic setIn(logic c, logic l, logic ep, logic et, logic up,
                       logic [3:0] lo, logic [3:0] hi);
    clrN = c; loadN = l; enLocal = ep; enChain = et; countUp = up; dLo = lo; dHi = hi;
  endtask

  task automatic cyc;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n;
    setIn(0, 1, 1, 1, 1, 4'd7, 4'd7);
    cyc();
    chk("R1 reset clear lo", qLo, 0);
    chk("R1 reset clear hi", qHi, 0);

    // R1 overrides an active load
    setIn(1, 0, 0, 0, 1, 4'd9, 4'd3); cyc();
    chk("R2 load lo", qLo, 9);
    chk("R2 load hi", qHi, 3);
    setIn(0, 0, 1, 1, 1, 4'd5, 4'd6); cyc();
    chk("R1 clear beats load lo", qLo, 0);
    chk("R1 clear beats load hi", qHi, 0);

    // R2 / R8: load every value with both enables low
    for (int v = 0; v < 16; v++) begin
      setIn(1, 0, 0, 0, v[0], 4'(v), 4'(15 - v)); cyc();
      chk("R8 load with enables off lo", qLo, v);
      chk("R2 load hi", qHi, 15 - v);
    end

    // R3..R7 on a single stage: every value, direction and enable pair
    for (int v = 0; v < 16; v++) begin
      for (int up = 0; up < 2; up++) begin
        for (int m = 0; m < 4; m++) begin
          int ep, et, expCarry, expQ;
          ep = m / 2; et = m % 2;
          setIn(1, 0, 0, 0, 1, 4'(v), 4'd0); cyc();
          setIn(1, 1, 1'(ep), 1'(et), 1'(up), 4'd0, 4'd0); #1;
          expCarry = (et == 1) && ((up == 1) ? (v == 15) : (v == 0));
          if (ep == 0) chk("R7 carry ignores enLocal", carryLo, expCarry);
          else         chk("R6 carry", carryLo, expCarry);
          cyc();
          if (ep == 1 && et == 1) begin
            expQ = (up == 1) ? (v + 1) % 16 : (v + 15) % 16;
            if (up == 1) chk("R4 count up", qLo, expQ);
            else         chk("R5 count down", qLo, expQ);
          end else begin
            chk("R3 hold", qLo, v);
          end
        end
      end
    end

    // R9: two chained stages, full 8-bit range up then down
    setIn(1, 0, 0, 0, 1, 4'd0, 4'd0); cyc();
    n = 0;
    setIn(1, 1, 1, 1, 1, 4'd0, 4'd0);
    for (int i = 0; i < 300; i++) begin
      #1;
      chk("R9 chained carry up", carryHi, (n == 255) ? 1 : 0);
      cyc();
      n = (n + 1) % 256;
      chk("R9 chained count up", {qHi, qLo}, n);
    end
    setIn(1, 1, 1, 1, 0, 4'd0, 4'd0);
    for (int i = 0; i < 300; i++) begin
      #1;
      chk("R9 chained carry down", carryHi, (n == 0) ? 1 : 0);
      cyc();
      n = (n + 255) % 256;
      chk("R9 chained count down", {qHi, qLo}, n);
    end

    // R8: direction reversal takes effect at the very next edge
    setIn(1, 1, 1, 1, 1, 4'd0, 4'd0); cyc();
    n = (n + 1) % 256;
    chk("R8 direction sampled up", {qHi, qLo}, n);
    setIn(1, 1, 1, 1, 0, 4'd0, 4'd0); cyc();
    n = (n + 255) % 256;
    chk("R8 direction sampled down", {qHi, qLo}, n);

    report();
  end

endmodule